// File: doc/BRIEF.md
# Condition Code Flag Generator

This block owns the 8-bit condition code register of a small 8/16-bit processor datapath. On each cycle with the update strobe high, the arithmetic unit presents the two operands, the result one bit wider than the operands (so the carry-out is bit 8 or bit 16), an operation class and an operand-width select. The block derives new half-carry, negative, zero, overflow and carry flags and merges them into the register under a per-flag update mask. Flags that the mask leaves out keep their previous value.

Increment and decrement have their own overflow rule, which depends only on the result. They never touch carry or half-carry. The logical/load class clears overflow and also leaves carry and half-carry alone. The block also drives a signed less-than predicate for conditional branches, taken from the current register contents.

Top module: `ccg_top`

## Requirements
- R1: A synchronous active-high reset clears the register to 0x00. While `upd_en` is low, `cc_out` does not change.
- R2: The register bit layout is C=bit 0, V=bit 1, Z=bit 2, N=bit 3, H=bit 5. Bits 4, 6 and 7 never change. `upd_mask` bit 0 selects C, bit 1 V, bit 2 Z, bit 3 N and bit 4 H. A flag whose mask bit is 0 keeps its previous value.
- R3: N takes result bit 7 when `wide`=0 and result bit 15 when `wide`=1, for every operation class.
- R4: Z is set exactly when the truncated result is zero. The truncated result is bits 7:0 when narrow and bits 15:0 when wide. This holds for every operation class.
- R5: For the add/subtract class (`op_sel`=0), C takes result bit 8 (narrow) or result bit 16 (wide).
- R6: For the add/subtract class, V is bit 7 (narrow) or bit 15 (wide) of a XOR b XOR r XOR (r shifted right by one). Here r is the full 17-bit result.
- R7: For the add/subtract class, H is bit 4 of a XOR b XOR r.
- R8: For increment (`op_sel`=1), V is set only when the truncated result is 0x80 (narrow) or 0x8000 (wide).
- R9: For decrement (`op_sel`=2), V is set only when the truncated result is 0x7F (narrow) or 0x7FFF (wide).
- R10: Increment, decrement and logical/load (`op_sel`=3) leave C and H unchanged even when their mask bits are set. Logical/load clears V when its mask bit is set.
- R11: `signed_lt` equals N XOR V of the current register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Register update strobe |
| op_sel | input | 2 | Class: 0 add/sub, 1 increment, 2 decrement, 3 logical/load |
| wide | input | 1 | 0 for 8-bit operation, 1 for 16-bit operation |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| raw_res | input | 17 | Result including carry-out bit |
| upd_mask | input | 5 | Affected flags {H,N,Z,V,C} |
| cc_out | output | 8 | Condition code register |
| signed_lt | output | 1 | Signed less-than predicate, N XOR V |

## Verification
The bench goes after the overflow edges of increment and decrement. These are 0x7F to 0x80 and 0x80 to 0x7F, plus their 16-bit forms. A design that reused the add/subtract overflow formula, or tested the wrong constant, would flag overflow on the wrong step. It also exercises narrow adds whose upper operand bits are non-zero. A design that took the zero or negative flag from the untruncated result would then report a non-zero value as zero, or pick the wrong sign bit. Partial masks and all-zero masks check that untouched flags survive. Increment and logical operations run with carry and half-carry set beforehand, so a design that cleared those bits would show up.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    localparam int NARROW_W = 8;
    localparam int WIDE_W   = 16;
    localparam int CC_W     = 8;

    localparam int POS_C = 0;
    localparam int POS_V = 1;
    localparam int POS_Z = 2;
    localparam int POS_N = 3;
    localparam int POS_H = 5;

    typedef enum logic [1:0] {
        OPC_ARITH = 2'd0,
        OPC_INC   = 2'd1,
        OPC_DEC   = 2'd2,
        OPC_LOGIC = 2'd3
    } opc_e;

    // Flag set ordered to match the update mask: {h,n,z,v,c}
    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flagset_t;

    localparam int FLAG_N = $bits(flagset_t);

    function automatic flagset_t cc_unpack(input logic [CC_W-1:0] cc);
        flagset_t f;
        f.h = cc[POS_H];
        f.n = cc[POS_N];
        f.z = cc[POS_Z];
        f.v = cc[POS_V];
        f.c = cc[POS_C];
        return f;
    endfunction

    function automatic logic [CC_W-1:0] cc_pack(input flagset_t f,
                                                input logic [CC_W-1:0] base);
        logic [CC_W-1:0] cc;
        cc        = base;
        cc[POS_H] = f.h;
        cc[POS_N] = f.n;
        cc[POS_Z] = f.z;
        cc[POS_V] = f.v;
        cc[POS_C] = f.c;
        return cc;
    endfunction

endpackage

// File: rtl/ccg_flag_calc.sv
module ccg_flag_calc
    import ccg_pkg::*;
#(
    parameter int NW = NARROW_W,
    parameter int WW = WIDE_W
) (
    input  opc_e            opc,
    input  logic            wide,
    input  logic [WW-1:0]   a,
    input  logic [WW-1:0]   b,
    input  logic [WW:0]     r,
    input  flagset_t        prev,
    output flagset_t        cand
);
    localparam int HALF_BIT = NW / 2;
    localparam logic [NW-1:0] N_MIN = {1'b1, {(NW-1){1'b0}}};
    localparam logic [NW-1:0] N_MAX = {1'b0, {(NW-1){1'b1}}};
    localparam logic [WW-1:0] W_MIN = {1'b1, {(WW-1){1'b0}}};
    localparam logic [WW-1:0] W_MAX = {1'b0, {(WW-1){1'b1}}};

    logic [WW-1:0] sum_x;
    logic [WW-1:0] ovf_x;
    logic          sign_bit;
    logic          is_zero;
    logic          arith_v;
    logic          arith_c;
    logic          arith_h;
    logic          at_min;
    logic          at_max;

    always_comb begin
        sum_x    = a ^ b ^ r[WW-1:0];
        ovf_x    = sum_x ^ r[WW:1];
        sign_bit = wide ? r[WW-1] : r[NW-1];
        is_zero  = wide ? (r[WW-1:0] == '0) : (r[NW-1:0] == '0);
        arith_v  = wide ? ovf_x[WW-1] : ovf_x[NW-1];
        arith_c  = wide ? r[WW] : r[NW];
        arith_h  = sum_x[HALF_BIT];
        at_min   = wide ? (r[WW-1:0] == W_MIN) : (r[NW-1:0] == N_MIN);
        at_max   = wide ? (r[WW-1:0] == W_MAX) : (r[NW-1:0] == N_MAX);
    end

    always_comb begin
        cand   = prev;
        cand.n = sign_bit;
        cand.z = is_zero;
        unique case (opc)
            OPC_ARITH: begin
                cand.v = arith_v;
                cand.c = arith_c;
                cand.h = arith_h;
            end
            OPC_INC:   cand.v = at_min;
            OPC_DEC:   cand.v = at_max;
            OPC_LOGIC: cand.v = 1'b0;
            default:   cand.v = prev.v;
        endcase
    end

endmodule

// File: rtl/ccg_mask_merge.sv
module ccg_mask_merge
    import ccg_pkg::*;
(
    input  flagset_t              prev,
    input  flagset_t              cand,
    input  logic [FLAG_N-1:0]     mask,
    output flagset_t              merged
);
    logic [FLAG_N-1:0] prev_v;
    logic [FLAG_N-1:0] cand_v;
    logic [FLAG_N-1:0] out_v;

    assign prev_v = prev;
    assign cand_v = cand;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
        assign out_v[i] = mask[i] ? cand_v[i] : prev_v[i];
    end

    assign merged = flagset_t'(out_v);

endmodule

// File: rtl/ccg_top.sv
module ccg_top
    import ccg_pkg::*;
#(
    parameter int NW = NARROW_W,
    parameter int WW = WIDE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [1:0]        op_sel,
    input  logic              wide,
    input  logic [WW-1:0]     opnd_a,
    input  logic [WW-1:0]     opnd_b,
    input  logic [WW:0]       raw_res,
    input  logic [FLAG_N-1:0] upd_mask,
    output logic [CC_W-1:0]   cc_out,
    output logic              signed_lt
);
    logic [CC_W-1:0] cc_q;
    flagset_t        prev_f;
    flagset_t        cand_f;
    flagset_t        next_f;

    assign prev_f = cc_unpack(cc_q);

    ccg_flag_calc #(.NW(NW), .WW(WW)) i_calc (
        .opc  (opc_e'(op_sel)),
        .wide (wide),
        .a    (opnd_a),
        .b    (opnd_b),
        .r    (raw_res),
        .prev (prev_f),
        .cand (cand_f)
    );

    ccg_mask_merge i_merge (
        .prev   (prev_f),
        .cand   (cand_f),
        .mask   (upd_mask),
        .merged (next_f)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q <= '0;
        end else if (upd_en) begin
            cc_q <= cc_pack(next_f, cc_q);
        end
    end

    assign cc_out    = cc_q;
    assign signed_lt = prev_f.n ^ prev_f.v;

endmodule

// File: rtl/ccg_checker.sv
module ccg_checker #(
    parameter int NW = 8,
    parameter int WW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          upd_en,
    input logic [1:0]    op_sel,
    input logic          wide,
    input logic [WW:0]   raw_res,
    input logic [4:0]    upd_mask,
    input logic [7:0]    cc_out,
    input logic          signed_lt
);
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> cc_out == 8'h00);

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(cc_out));

    p_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable({cc_out[7:6], cc_out[4]}));

    p_mask_keep_c_r2: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_mask[0]) |=> $stable(cc_out[0]));

    p_zero_trunc_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_mask[2]) |=>
        cc_out[2] == ($past(wide) ? ($past(raw_res[WW-1:0]) == '0)
                                  : ($past(raw_res[NW-1:0]) == '0)));

    p_inc_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_mask[1] && op_sel == 2'd1 && !wide &&
         raw_res[NW-1:0] != {1'b1, {(NW-1){1'b0}}}) |=> !cc_out[1]);

    p_logic_keep_c_r10: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sel != 2'd0) |=> $stable({cc_out[5], cc_out[0]}));

    p_lt_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> signed_lt == (cc_out[3] != cc_out[1]));

endmodule

bind ccg_top ccg_checker #(.NW(NW), .WW(WW)) i_ccg_checker (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (upd_en),
    .op_sel    (op_sel),
    .wide      (wide),
    .raw_res   (raw_res),
    .upd_mask  (upd_mask),
    .cc_out    (cc_out),
    .signed_lt (signed_lt)
);

// File: tb/test_ccg_top.sv
`timescale 1ns/1ps
module test_ccg_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        upd_en;
    logic [1:0]  op_sel;
    logic        wide;
    logic [15:0] opnd_a;
    logic [15:0] opnd_b;
    logic [16:0] raw_res;
    logic [4:0]  upd_mask;
    logic [7:0]  cc_out;
    logic        signed_lt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [7:0] model_cc;

    always #2.5 clk = ~clk;

    ccg_top i_ccg_top (
        .clk(clk), .rst(rst), .upd_en(upd_en), .op_sel(op_sel), .wide(wide),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .raw_res(raw_res),
        .upd_mask(upd_mask), .cc_out(cc_out), .signed_lt(signed_lt)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic logic [7:0] ref_cc(input logic [7:0] p, input int opc,
            input bit w, input logic [15:0] a, input logic [15:0] b,
            input logic [16:0] r, input logic [4:0] m);
        int msb = w ? 15 : 7;
        logic [15:0] t = w ? r[15:0] : {8'h00, r[7:0]};
        logic [15:0] xv = a ^ b ^ r[15:0] ^ r[16:1];
        logic [7:0] q = p;
        logic nn = r[msb];
        logic zz = (t == 16'h0);
        logic vv = p[1];
        logic cc = p[0];
        logic hh = p[5];
        if (opc == 0) begin
            vv = xv[msb];
            cc = r[msb + 1];
            hh = a[4] ^ b[4] ^ r[4];
        end else if (opc == 1) vv = w ? (t == 16'h8000) : (t == 16'h0080);
        else if (opc == 2)     vv = w ? (t == 16'h7fff) : (t == 16'h007f);
        else                   vv = 1'b0;
        if (m[0]) q[0] = cc;
        if (m[1]) q[1] = vv;
        if (m[2]) q[2] = zz;
        if (m[3]) q[3] = nn;
        if (m[4]) q[5] = hh;
        return q;
    endfunction

    task automatic apply(input int opc, input bit w, input logic [15:0] a,
                         input logic [15:0] b, input logic [16:0] r, input logic [4:0] m);
        logic [7:0] e;
        e = ref_cc(model_cc, opc, w, a, b, r, m);
        @(negedge clk);
        upd_en = 1'b1; op_sel = opc[1:0]; wide = w;
        opnd_a = a; opnd_b = b; raw_res = r; upd_mask = m;
        @(negedge clk);
        upd_en = 1'b0;
        check(m[3] ? "R3 N" : "R2 N kept", {15'h0, cc_out[3]}, {15'h0, e[3]});
        check(m[2] ? "R4 Z" : "R2 Z kept", {15'h0, cc_out[2]}, {15'h0, e[2]});
        check(!m[1] ? "R2 V kept" : opc == 0 ? "R6 V" : opc == 1 ? "R8 V" :
              opc == 2 ? "R9 V" : "R10 V", {15'h0, cc_out[1]}, {15'h0, e[1]});
        check(!m[0] ? "R2 C kept" : opc == 0 ? "R5 C" : "R10 C",
              {15'h0, cc_out[0]}, {15'h0, e[0]});
        check(!m[4] ? "R2 H kept" : opc == 0 ? "R7 H" : "R10 H",
              {15'h0, cc_out[5]}, {15'h0, e[5]});
        check("R2 reserved", {8'h0, cc_out & 8'hd0}, 16'h0);
        check("R11 lt", {15'h0, signed_lt}, {15'h0, e[3] ^ e[1]});
        model_cc = e;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] a, b;
        logic [16:0] r;
        int opc;
        bit w;
        void'($urandom(32'd20240611));
        rst = 1'b1; upd_en = 1'b0; op_sel = 2'd0; wide = 1'b0;
        opnd_a = '0; opnd_b = '0; raw_res = '0; upd_mask = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", {8'h0, cc_out}, 16'h0000);
        rst = 1'b0;
        model_cc = 8'h00;

        // Directed corners
        apply(0, 0, 16'h00ff, 16'h0001, 17'h00100, 5'h1f); // carry, zero, half
        apply(1, 0, 16'h007f, 16'h0001, 17'h00080, 5'h1f); // inc to 0x80
        apply(1, 0, 16'h0080, 16'h0001, 17'h00081, 5'h1f);
        apply(2, 0, 16'h0080, 16'h0001, 17'h0007f, 5'h1f); // dec to 0x7f
        apply(2, 0, 16'h007f, 16'h0001, 17'h0007e, 5'h1f);
        apply(1, 1, 16'h7fff, 16'h0001, 17'h08000, 5'h1f);
        apply(2, 1, 16'h8000, 16'h0001, 17'h07fff, 5'h1f);
        apply(2, 1, 16'h0080, 16'h0001, 17'h0007f, 5'h1f); // wide, no overflow
        apply(0, 0, 16'h7f00, 16'h0100, 17'h08000, 5'h1f); // narrow zero with upper bits
        apply(0, 0, 16'h0070, 16'h0010, 17'h00080, 5'h1f); // narrow overflow
        apply(3, 0, 16'h0000, 16'h0000, 17'h00000, 5'h1f); // logic keeps C/H
        apply(0, 1, 16'hffff, 16'hffff, 17'h1fffe, 5'h00); // mask none
        apply(0, 1, 16'h8000, 16'h8000, 17'h10000, 5'h05); // partial mask

        // Hold while idle
        begin
            logic [7:0] held;
            held = cc_out;
            @(negedge clk);
            opnd_a = 16'h1234; raw_res = 17'h00000; upd_mask = 5'h1f; op_sel = 2'd0;
            repeat (3) @(negedge clk);
            check("R1 hold", {8'h0, cc_out}, {8'h0, held});
        end

        // Constrained random
        for (int i = 0; i < 600; i++) begin
            opc = int'($urandom_range(0, 3));
            w   = 1'($urandom_range(0, 1));
            a   = 16'($urandom);
            b   = 16'($urandom);
            case (opc)
                0: r = ($urandom_range(0, 1) != 0) ? ({1'b0, a} + {1'b0, b})
                                                   : ({1'b0, a} - {1'b0, b});
                1: r = {1'b0, a} + 17'd1;
                2: r = {1'b0, a} - 17'd1;
                default: r = {1'b0, a & b};
            endcase
            if (!w && opc == 0) r = {8'h00, 9'({1'b0, a[7:0]} + {1'b0, b[7:0]})};
            apply(opc, w, a, b, r, 5'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule